// File: doc/BRIEF.md
# Edge-Interrupt GPIO Bank

A bank of general-purpose pins behind a simple word-addressed register bus. Software drives output levels and pin directions only through paired set and clear registers, so one write changes exactly the bits it names and no read-modify-write sequence is ever needed. Every pin input is resynchronised into the clock domain and then watched for edges.

A rising or a falling edge is latched into a pending-status register when the matching per-pin enable bit is set. Software clears pending bits by writing ones. A combined interrupt line is high while any bit is pending. A second, independent pair of edge masks produces a one-cycle wake pulse. Two select registers form a two-bit alternate-function code per pin, and a per-pin sleep-control register is kept for software. Only edge triggering exists; there is no level mode.

Top module: `gpio_bank`

## Requirements
- R1: After reset every register reads 0, `pin_out`, `pin_oe` and `alt_code` are 0, and `irq` and `wake` are low.
- R2: A write to word 1 sets the output-data bits given as ones and a write to word 2 clears them; zero bits leave those outputs alone. Word 1 reads back the output data, which drives `pin_out`.
- R3: A write to word 3 makes the pins given as ones outputs and a write to word 4 makes them inputs. Word 3 reads back the direction (1 output, 0 input), which drives `pin_oe`.
- R4: Word 0 reads the pin levels through a two-stage synchroniser: a pin change made between two clock edges shows on the second following edge.
- R5: A rising edge sets a pin's pending bit (word 7) only when its bit in the rising enable (word 5) is set, and a falling edge only when its bit in the falling enable (word 6) is set. The bit becomes set on the third edge after the pin change.
- R6: Writing ones to word 8 clears those pending bits and zeros leave them; when an enabled edge arrives in the same cycle as the clear of that bit, the bit stays set.
- R7: `irq` is high exactly while at least one pending bit is set.
- R8: `wake` pulses high for one cycle, on the same edge a pending bit would be set, when a rising edge hits the rising wake mask (word 9) or a falling edge hits the falling wake mask (word 10); these masks are independent of words 5 and 6 and leave word 7 untouched.
- R9: Words 11 (select A) and 12 (select B) are read/write; `alt_code[2p+1:2p]` for pin p equals A bit + 2 times B bit, 0 meaning plain GPIO.
- R10: Word 13 is a read/write sleep-control register, one bit per pin.
- R11: Writes to words 0 and 7 and to any word above 13 change no state; words 2, 4, 8 and words above 13 read as 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_wr | input | 1 | Write strobe for one cycle |
| bus_addr | input | AW | Register word index |
| bus_wdata | input | NPINS | Write data |
| bus_rdata | output | NPINS | Read data for `bus_addr`, combinational |
| pin_in | input | NPINS | Pin input levels, asynchronous |
| pin_out | output | NPINS | Output data |
| pin_oe | output | NPINS | Output enable, 1 = output |
| alt_code | output | 2*NPINS | Per-pin alternate-function code |
| irq | output | 1 | Any pending edge |
| wake | output | 1 | One-cycle wake event pulse |

## Verification
The bench builds the bank with its full width of 32 pins, two synchroniser stages and a four-bit address. At that width the top pin, bit 31, can take edges and set or clear pending bits, and the top alternate code field lies at the end of the vector. With the four-bit address, word 15 is reachable as an unmapped location. The two-stage setting gives a fixed three-edge delay from a pin change to a pending bit, so a clear write can be placed on exactly the edge where an enabled edge lands.

// File: rtl/gpio_bank_pkg.sv
package gpio_bank_pkg;
   // register word indices; the map is compact and starts at zero
   localparam int RG_LEVEL    = 0;
   localparam int RG_OUT_SET  = 1;
   localparam int RG_OUT_CLR  = 2;
   localparam int RG_DIR_SET  = 3;
   localparam int RG_DIR_CLR  = 4;
   localparam int RG_RISE_EN  = 5;
   localparam int RG_FALL_EN  = 6;
   localparam int RG_STATUS   = 7;
   localparam int RG_STAT_CLR = 8;
   localparam int RG_RWAKE_EN = 9;
   localparam int RG_FWAKE_EN = 10;
   localparam int RG_ALT_A    = 11;
   localparam int RG_ALT_B    = 12;
   localparam int RG_SLEEP    = 13;
   localparam int RG_COUNT    = 14;
endpackage

// File: rtl/gpio_sync.sv
module gpio_sync #(
   parameter int W      = 32,
   parameter int STAGES = 2
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [W-1:0] d,
   output logic [W-1:0] q
);
   localparam int CHAIN = STAGES * W;

   logic [CHAIN-1:0] chain_q;

   generate
      if (STAGES == 1) begin : g_single
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) chain_q <= '0;
            else        chain_q <= d;
         end
      end else begin : g_multi
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) chain_q <= '0;
            else        chain_q <= {chain_q[CHAIN-W-1:0], d};
         end
      end
   endgenerate

   assign q = chain_q[CHAIN-1 -: W];
endmodule

// File: rtl/gpio_edge.sv
module gpio_edge #(
   parameter int W = 32
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [W-1:0] lvl,
   input  logic [W-1:0] rise_en,
   input  logic [W-1:0] fall_en,
   input  logic [W-1:0] rwake_en,
   input  logic [W-1:0] fwake_en,
   input  logic [W-1:0] clr_mask,
   output logic [W-1:0] status,
   output logic         wake
);
   logic [W-1:0] prev_q;
   logic [W-1:0] rise, fall, hit, wake_hits;

   assign rise      = lvl & ~prev_q;
   assign fall      = ~lvl & prev_q;
   assign hit       = (rise & rise_en) | (fall & fall_en);
   assign wake_hits = (rise & rwake_en) | (fall & fwake_en);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         prev_q <= '0;
         status <= '0;
         wake   <= 1'b0;
      end else begin
         prev_q <= lvl;
         // a fresh edge outranks a clear of the same bit
         status <= (status & ~clr_mask) | hit;
         wake   <= |wake_hits;
      end
   end

   // R5
   stat_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
      ((status & ~$past(status) & ~$past(hit)) == '0));
   // R6
   stat_clr_chk: assert property (@(posedge clk) disable iff (!rst_n)
      ((status & $past(clr_mask) & ~$past(hit)) == '0));
   // R8
   wake_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
      wake |-> $past(|wake_hits));
endmodule

// File: rtl/gpio_regs.sv
module gpio_regs
   import gpio_bank_pkg::*;
#(
   parameter int W  = 32,
   parameter int AW = 4
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          bus_wr,
   input  logic [AW-1:0] bus_addr,
   input  logic [W-1:0]  bus_wdata,
   output logic [W-1:0]  bus_rdata,
   input  logic [W-1:0]  lvl,
   input  logic [W-1:0]  status,
   output logic [W-1:0]  dout,
   output logic [W-1:0]  dir,
   output logic [W-1:0]  rise_en,
   output logic [W-1:0]  fall_en,
   output logic [W-1:0]  rwake_en,
   output logic [W-1:0]  fwake_en,
   output logic [W-1:0]  alt_a,
   output logic [W-1:0]  alt_b,
   output logic [W-1:0]  clr_mask
);
   logic [W-1:0] sleep_q;
   logic we_oset, we_oclr, we_dset, we_dclr;

   assign we_oset  = bus_wr && (bus_addr == AW'(RG_OUT_SET));
   assign we_oclr  = bus_wr && (bus_addr == AW'(RG_OUT_CLR));
   assign we_dset  = bus_wr && (bus_addr == AW'(RG_DIR_SET));
   assign we_dclr  = bus_wr && (bus_addr == AW'(RG_DIR_CLR));
   assign clr_mask = (bus_wr && (bus_addr == AW'(RG_STAT_CLR))) ? bus_wdata : '0;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         dout     <= '0;
         dir      <= '0;
         rise_en  <= '0;
         fall_en  <= '0;
         rwake_en <= '0;
         fwake_en <= '0;
         alt_a    <= '0;
         alt_b    <= '0;
         sleep_q  <= '0;
      end else begin
         if (we_oset) dout <= dout | bus_wdata;
         if (we_oclr) dout <= dout & ~bus_wdata;
         if (we_dset) dir  <= dir | bus_wdata;
         if (we_dclr) dir  <= dir & ~bus_wdata;
         if (bus_wr) begin
            case (bus_addr)
               AW'(RG_RISE_EN):  rise_en  <= bus_wdata;
               AW'(RG_FALL_EN):  fall_en  <= bus_wdata;
               AW'(RG_RWAKE_EN): rwake_en <= bus_wdata;
               AW'(RG_FWAKE_EN): fwake_en <= bus_wdata;
               AW'(RG_ALT_A):    alt_a    <= bus_wdata;
               AW'(RG_ALT_B):    alt_b    <= bus_wdata;
               AW'(RG_SLEEP):    sleep_q  <= bus_wdata;
               default: ;
            endcase
         end
      end
   end

   always_comb begin
      case (bus_addr)
         AW'(RG_LEVEL):    bus_rdata = lvl;
         AW'(RG_OUT_SET):  bus_rdata = dout;
         AW'(RG_DIR_SET):  bus_rdata = dir;
         AW'(RG_RISE_EN):  bus_rdata = rise_en;
         AW'(RG_FALL_EN):  bus_rdata = fall_en;
         AW'(RG_STATUS):   bus_rdata = status;
         AW'(RG_RWAKE_EN): bus_rdata = rwake_en;
         AW'(RG_FWAKE_EN): bus_rdata = fwake_en;
         AW'(RG_ALT_A):    bus_rdata = alt_a;
         AW'(RG_ALT_B):    bus_rdata = alt_b;
         AW'(RG_SLEEP):    bus_rdata = sleep_q;
         default:          bus_rdata = '0;
      endcase
   end

   // R2
   out_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $past(we_oset) |-> ((dout & $past(bus_wdata)) == $past(bus_wdata)));
   // R2
   out_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $past(we_oset) |-> ((dout & ~$past(bus_wdata)) == ($past(dout) & ~$past(bus_wdata))));
   // R3
   dir_clr_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $past(we_dclr) |-> ((dir & $past(bus_wdata)) == '0));
endmodule

// File: rtl/gpio_bank.sv
module gpio_bank
   import gpio_bank_pkg::*;
#(
   parameter int NPINS       = 32,
   parameter int SYNC_STAGES = 2,
   parameter int AW          = 4
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               bus_wr,
   input  logic [AW-1:0]      bus_addr,
   input  logic [NPINS-1:0]   bus_wdata,
   output logic [NPINS-1:0]   bus_rdata,
   input  logic [NPINS-1:0]   pin_in,
   output logic [NPINS-1:0]   pin_out,
   output logic [NPINS-1:0]   pin_oe,
   output logic [2*NPINS-1:0] alt_code,
   output logic               irq,
   output logic               wake
);
   localparam int MIN_AW = $clog2(RG_COUNT);

   generate
      if (NPINS < 1 || NPINS > 64) begin : g_bad_npins
         $error("gpio_bank: NPINS must lie in 1..64");
      end
      if (AW < MIN_AW) begin : g_bad_aw
         $error("gpio_bank: AW too narrow for the register map");
      end
      if (SYNC_STAGES < 1) begin : g_bad_sync
         $error("gpio_bank: SYNC_STAGES must be at least 1");
      end
   endgenerate

   logic [NPINS-1:0] lvl, status, clr_mask;
   logic [NPINS-1:0] rise_en, fall_en, rwake_en, fwake_en, alt_a, alt_b;

   gpio_sync #(.W(NPINS), .STAGES(SYNC_STAGES)) u_sync (
      .clk (clk), .rst_n (rst_n), .d (pin_in), .q (lvl)
   );

   gpio_regs #(.W(NPINS), .AW(AW)) u_regs (
      .clk       (clk),
      .rst_n     (rst_n),
      .bus_wr    (bus_wr),
      .bus_addr  (bus_addr),
      .bus_wdata (bus_wdata),
      .bus_rdata (bus_rdata),
      .lvl       (lvl),
      .status    (status),
      .dout      (pin_out),
      .dir       (pin_oe),
      .rise_en   (rise_en),
      .fall_en   (fall_en),
      .rwake_en  (rwake_en),
      .fwake_en  (fwake_en),
      .alt_a     (alt_a),
      .alt_b     (alt_b),
      .clr_mask  (clr_mask)
   );

   gpio_edge #(.W(NPINS)) u_edge (
      .clk      (clk),
      .rst_n    (rst_n),
      .lvl      (lvl),
      .rise_en  (rise_en),
      .fall_en  (fall_en),
      .rwake_en (rwake_en),
      .fwake_en (fwake_en),
      .clr_mask (clr_mask),
      .status   (status),
      .wake     (wake)
   );

   generate
      for (genvar p = 0; p < NPINS; p++) begin : g_alt
         assign alt_code[2*p +: 2] = {alt_b[p], alt_a[p]};
      end
   endgenerate

   assign irq = |status;

   // R7
   irq_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      ($past(irq) && !$past(bus_wr)) |-> irq);
   // R1
   reset_quiet_chk: assert property (@(posedge clk)
      !rst_n |-> (!irq && !wake && pin_oe == '0));
endmodule

// File: tb/test_gpio_bank.sv
module test_gpio_bank;
   localparam int NP = 32;
   localparam int AW = 4;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic bus_wr = 1'b0;
   logic [AW-1:0] bus_addr = '0;
   logic [NP-1:0] bus_wdata = '0;
   logic [NP-1:0] pin_in = '0;
   logic [NP-1:0] bus_rdata, pin_out, pin_oe;
   logic [2*NP-1:0] alt_code;
   logic irq, wake;

   int n_cmp = 0;
   int n_bad = 0;
   bit done = 0;

   always #4 clk = ~clk;

   gpio_bank #(.NPINS(NP), .SYNC_STAGES(2), .AW(AW)) i_gpio_bank (
      .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_addr(bus_addr),
      .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .pin_in(pin_in),
      .pin_out(pin_out), .pin_oe(pin_oe), .alt_code(alt_code),
      .irq(irq), .wake(wake)
   );

   // behavioural reference state
   logic [31:0] m_s1 = 0, m_s2 = 0, m_prev = 0, m_out = 0, m_dir = 0;
   logic [31:0] m_ren = 0, m_fen = 0, m_rw = 0, m_fw = 0, m_a = 0, m_b = 0, m_slp = 0, m_st = 0;
   logic m_wake = 0;

   function automatic logic [31:0] m_read(input int a);
      case (a)
         0: return m_s2;   1: return m_out;  3: return m_dir;
         5: return m_ren;  6: return m_fen;  7: return m_st;
         9: return m_rw;  10: return m_fw;  11: return m_a;
         12: return m_b;  13: return m_slp;
         default: return 32'h0;
      endcase
   endfunction

   function automatic string tag_of(input int a);
      case (a)
         0: return "R4"; 1: return "R2"; 3: return "R3"; 5, 6, 7: return "R5";
         9, 10: return "R8"; 11, 12: return "R9"; 13: return "R10";
         default: return "R11";
      endcase
   endfunction

   task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
      n_cmp++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s: actual %h expected %h at %0t", tag, act, exp, $time);
      end
   endtask

   function automatic logic [63:0] m_alt();
      logic [63:0] r = '0;
      for (int p = 0; p < 32; p++) r[2*p +: 2] = {m_b[p], m_a[p]};
      return r;
   endfunction

   always @(posedge clk) begin
      if (!rst_n) begin
         m_s1 = 0; m_s2 = 0; m_prev = 0; m_out = 0; m_dir = 0; m_ren = 0; m_fen = 0;
         m_rw = 0; m_fw = 0; m_a = 0; m_b = 0; m_slp = 0; m_st = 0; m_wake = 0;
      end else begin
         logic [31:0] r, f, clr;
         r = m_s2 & ~m_prev;
         f = ~m_s2 & m_prev;
         clr = 0;
         m_wake = |((r & m_rw) | (f & m_fw));
         if (bus_wr) begin
            case (int'(bus_addr))
               1: m_out = m_out | bus_wdata;   2: m_out = m_out & ~bus_wdata;
               3: m_dir = m_dir | bus_wdata;   4: m_dir = m_dir & ~bus_wdata;
               8: clr = bus_wdata;
               default: ;
            endcase
         end
         m_st = (m_st & ~clr) | (r & m_ren) | (f & m_fen);
         if (bus_wr) begin
            case (int'(bus_addr))
               5: m_ren = bus_wdata;  6: m_fen = bus_wdata;
               9: m_rw = bus_wdata;  10: m_fw = bus_wdata;
               11: m_a = bus_wdata;  12: m_b = bus_wdata;  13: m_slp = bus_wdata;
               default: ;
            endcase
         end
         m_prev = m_s2; m_s2 = m_s1; m_s1 = pin_in;
      end
      #2;
      if (!done) begin
         chk(tag_of(int'(bus_addr)), 64'(bus_rdata), 64'(m_read(int'(bus_addr))));
         chk("R2", 64'(pin_out), 64'(m_out));
         chk("R3", 64'(pin_oe), 64'(m_dir));
         chk("R7", 64'(irq), 64'(m_st != 0));
         chk("R8", 64'(wake), 64'(m_wake));
         chk("R9", alt_code, m_alt());
      end
   end

   task automatic wr(input int a, input logic [31:0] d);
      @(negedge clk);
      bus_wr = 1'b1; bus_addr = AW'(a); bus_wdata = d;
      @(negedge clk);
      bus_wr = 1'b0; bus_wdata = '0;
   endtask

   task automatic rd_chk(input string tag, input int a, input logic [31:0] exp);
      @(negedge clk);
      bus_addr = AW'(a);
      @(posedge clk); #2;
      chk(tag, 64'(bus_rdata), 64'(exp));
   endtask

   task automatic finish_run();
      if (!done) begin
         done = 1;
         $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
         $finish;
      end
   endtask

   initial begin
      #(8 * 200000);
      n_cmp++; n_bad++;
      $display("FAIL watchdog: actual hung expected finish");
      finish_run();
   end

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      // R1 reset state
      for (int a = 0; a < 16; a++) rd_chk("R1", a, 32'h0);
      chk("R1", {pin_out, pin_oe}, 64'h0);
      chk("R1", {62'h0, irq, wake}, 64'h0);

      // R2 output set / clear
      wr(1, 32'hA5A5_0001); rd_chk("R2", 1, 32'hA5A5_0001);
      wr(2, 32'h0000_0001); rd_chk("R2", 1, 32'hA5A5_0000);
      wr(1, 32'h0);         rd_chk("R2", 1, 32'hA5A5_0000);
      chk("R2", 64'(pin_out), 64'hA5A5_0000);

      // R3 direction set / clear
      wr(3, 32'hFFFF_0000); wr(4, 32'h0F00_0000);
      rd_chk("R3", 3, 32'hF0FF_0000);
      chk("R3", 64'(pin_oe), 64'hF0FF_0000);

      // R4 two-stage synchroniser delay
      @(negedge clk); bus_addr = AW'(0); pin_in = 32'h1234_5678;
      @(posedge clk); #2; chk("R4", 64'(bus_rdata), 64'h0);
      @(posedge clk); #2; chk("R4", 64'(bus_rdata), 64'h1234_5678);
      repeat (3) @(posedge clk);
      rd_chk("R5", 7, 32'h0);

      // R5 masked edges; bit 31 and bit 0 rise enabled, bit 1 fall enabled
      wr(5, 32'h8000_0001); wr(6, 32'h0000_0002);
      @(negedge clk); bus_addr = AW'(7); pin_in = 32'h8000_0003;
      @(posedge clk); @(posedge clk); #2; chk("R5", 64'(bus_rdata), 64'h0);
      @(posedge clk); #2; chk("R5", 64'(bus_rdata), 64'h8000_0001);
      chk("R7", 64'(irq), 64'h1);
      @(negedge clk); pin_in = 32'h8000_0001;
      repeat (3) @(posedge clk); #2; chk("R5", 64'(bus_rdata), 64'h8000_0003);

      // R6 write-one-to-clear, zeros keep
      wr(8, 32'h1); rd_chk("R6", 7, 32'h8000_0002);
      wr(8, 32'h0); rd_chk("R6", 7, 32'h8000_0002);
      // R6 set wins over a clear in the same cycle
      @(negedge clk); pin_in = 32'h8000_0000;
      repeat (4) @(negedge clk);
      pin_in = 32'h8000_0001;
      @(negedge clk); @(negedge clk);
      bus_wr = 1'b1; bus_addr = AW'(8); bus_wdata = 32'h1;
      @(posedge clk); #2;
      @(negedge clk); bus_wr = 1'b0; bus_wdata = '0;
      rd_chk("R6", 7, 32'h8000_0003);
      wr(8, 32'hFFFF_FFFF); rd_chk("R6", 7, 32'h0);
      chk("R7", 64'(irq), 64'h0);

      // R8 wake independent of normal masks
      wr(5, 32'h0); wr(6, 32'h0); wr(9, 32'h0000_0010);
      @(negedge clk); pin_in = 32'h8000_0011;
      @(posedge clk); @(posedge clk); #2; chk("R8", 64'(wake), 64'h0);
      @(posedge clk); #2; chk("R8", 64'(wake), 64'h1);
      @(posedge clk); #2; chk("R8", 64'(wake), 64'h0);
      rd_chk("R8", 7, 32'h0);
      wr(10, 32'h0000_0010);
      @(negedge clk); pin_in = 32'h8000_0001;
      repeat (3) @(posedge clk); #2; chk("R8", 64'(wake), 64'h1);

      // R9 alternate code
      wr(11, 32'h5); wr(12, 32'h6);
      @(posedge clk); #2; chk("R9", 64'(alt_code[7:0]), 64'h39);
      // R10 sleep control
      wr(13, 32'hDEAD_BEEF); rd_chk("R10", 13, 32'hDEAD_BEEF);

      // R11 writes to read-only and unmapped words
      wr(0, 32'hFFFF_FFFF); wr(7, 32'hFFFF_FFFF); wr(15, 32'hFFFF_FFFF);
      rd_chk("R11", 7, 32'h0);
      rd_chk("R11", 15, 32'h0);
      rd_chk("R11", 2, 32'h0);
      chk("R11", {pin_out, pin_oe}, {32'hA5A5_0000, 32'hF0FF_0000});

      // mixed traffic against the reference model
      for (int i = 0; i < 600; i++) begin
         @(negedge clk);
         bus_wr = ($urandom_range(0, 2) == 0);
         bus_addr = AW'($urandom_range(0, 15));
         bus_wdata = $urandom();
         if ($urandom_range(0, 3) == 0) pin_in = pin_in ^ $urandom();
      end
      @(negedge clk); bus_wr = 1'b0;
      repeat (4) @(posedge clk);
      #1;
      finish_run();
   end
endmodule